// File: doc/BRIEF.md
# Byte-Wide Host Register Interface for a Sampling Converter

This block is the host-side register file of a sampling converter that sits on an 8-bit parallel bus with active-low chip select, read and write strobes and a byte-steering line (`hben`). Each register write carries a 16-bit word split over two byte transfers on `db[7:0]`: the low byte is sent with `hben` low, then the high byte with `hben` high. Bits 15:14 of the assembled word pick the destination, and bits 13:0 are stored there. The destinations are a test register, one of four calibration registers, or the control register. The control register drives the converter core: power mode, input range, a convert request, calibration mode and selection, and a calibration request. It also holds two sticky read-select bits that decide what every later read returns.

Reads return the conversion result, the test register, a calibration register or a status word. Most sources give twelve bits on `db[11:0]` when `hben` is low, and the upper byte on `db[7:0]` when `hben` is high. A calibration register is read as two bytes, low byte first, and a read pointer steps between them. The bus is driven only while a read is in progress and floats at all other times.

Strobes are sampled on `clk`. A write transfer is taken on the first clock at which `wr_n` is seen low with `cs_n` low, after `wr_n` was high on the clock before. A read ends on the first clock at which the pair (`cs_n`, `rd_n`) is no longer both low. The write pointer has two states, WP_LOW and WP_HIGH. A low-byte transfer moves it to WP_HIGH. A high-byte transfer taken in WP_HIGH commits the word and moves it back to WP_LOW. The calibration read pointer also has two states, CP_LOW and CP_HIGH. It toggles at the end of each read while calibration is the read source, and any control write sends it back to CP_LOW.

Top module: `byte_reg_if`

## Requirements
- R1: After reset, every control output is 0, the write pointer expects a low byte, and the read source is the conversion result.
- R2: A low-byte transfer (`hben`=0) followed by a high-byte transfer (`hben`=1), each on `db[7:0]`, commits the word {high, low} on the clock that takes the high byte. The next transfer is then expected to be a low byte.
- R3: A high-byte transfer that arrives while a low byte is expected is ignored. A low-byte transfer that arrives while a high byte is expected replaces the held low byte.
- R4: Word bits 15:14 select the destination: 00 none, 01 test register, 10 calibration register, 11 control register. Bits 13:0 are stored in the selected register, and a 00 word changes nothing.
- R5: Control word fields: bits 9:8 power mode, 7:6 read select, 5 input range, 4 convert request, 3 calibration mode, 2:1 calibration select, 0 calibration request. Bits 13:10 are ignored.
- R6: The convert request clears on a `conv_done` pulse and the calibration request clears on a `cal_done` pulse. A control write on the same clock takes precedence.
- R7: The read select chooses the read word: 00 gives {0000, result}, 01 gives {00, test}, 10 gives {00, calibration[cal select]}, and 11 gives the status word. The choice holds until the next control write.
- R8: For non-calibration sources, a read with `hben`=0 drives word[11:0] on `db[11:0]`. A read with `hben`=1 drives word[15:8] on `db[7:0]` with `db[11:8]`=0.
- R9: A calibration read returns word[7:0] first and word[15:8] second on `db[7:0]`, with `db[11:8]`=0 and regardless of `hben`. A control write restarts the sequence at the low byte.
- R10: A calibration-register write is ignored while the calibration request bit is set.
- R11: `db` is driven only while both `cs_n` and `rd_n` are low, and is high impedance otherwise.
- R12: Write and read strobes have no effect while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hben | input | 1 | Byte steering: 0 low byte / full word, 1 high byte |
| db | inout | 12 | Bidirectional data bus |
| result | input | 12 | Latest conversion result |
| status_word | input | 16 | Status word from the converter core |
| conv_done | input | 1 | Pulse: conversion finished |
| cal_done | input | 1 | Pulse: calibration finished |
| pwr_mode | output | 2 | Power mode field |
| range_bipolar | output | 1 | Input range select |
| conv_start | output | 1 | Convert request |
| cal_system | output | 1 | Calibration mode select |
| cal_sel | output | 2 | Calibration type / register select |
| cal_start | output | 1 | Calibration request |

## Verification
The hardest state to reach is a calibration read pointer caught halfway through a byte pair. That must be combined with a control write, a locked calibration request, and a write sequence where the bytes arrive out of order. The stimulus reaches these states with directed byte transfers: a high byte sent first, a low byte sent twice, a single calibration read followed by a control write, and a high-byte write landing on the same clock as `conv_done`. A behavioural model in the bench follows every clock and predicts both the control outputs and the bus value.

// File: rtl/bri_pkg.sv
package bri_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int PAYLOAD_W = 14;
    localparam int BUS_W     = 12;
    localparam int CTRL_W    = 10;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_TEST = 2'b01,
        TGT_CAL  = 2'b10,
        TGT_CTRL = 2'b11
    } target_e;

    typedef enum logic [1:0] {
        SRC_RESULT = 2'b00,
        SRC_TEST   = 2'b01,
        SRC_CAL    = 2'b10,
        SRC_STATUS = 2'b11
    } rdsrc_e;

    typedef enum logic {WP_LOW = 1'b0, WP_HIGH = 1'b1} wptr_e;
    typedef enum logic {CP_LOW = 1'b0, CP_HIGH = 1'b1} cptr_e;

    // packed order follows control word bits 9..0
    typedef struct packed {
        logic [1:0] pmgt;
        rdsrc_e     rdsel;
        logic       amode;
        logic       convst;
        logic       calmd;
        logic [1:0] calsel;
        logic       stcal;
    } ctrl_t;
endpackage

// File: rtl/bri_wr_assembler.sv
module bri_wr_assembler
    import bri_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          hben,
    input  logic [BW-1:0] din,
    output logic          commit,
    output logic [WW-1:0] word
);
    wptr_e         st, st_nxt;
    logic          wr_prev;
    logic          wr_evt;
    logic [BW-1:0] lo_byte;

    assign wr_evt = !cs_n && !wr_n && wr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= WP_LOW;
            wr_prev <= 1'b1;
            lo_byte <= '0;
        end else begin
            st      <= st_nxt;
            wr_prev <= wr_n;
            if (wr_evt && !hben)
                lo_byte <= din;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            WP_LOW:  if (wr_evt && !hben) st_nxt = WP_HIGH;
            WP_HIGH: if (wr_evt && hben)  st_nxt = WP_LOW;
            default: st_nxt = WP_LOW;
        endcase
    end

    always_comb begin
        commit = (st == WP_HIGH) && wr_evt && hben;
        word   = {din, lo_byte};
    end

    p_ptr_low_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st == WP_LOW));
    p_early_high_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WP_LOW && hben) |=> (st == WP_LOW));
    p_deselected_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(st) && $stable(lo_byte)));
endmodule

// File: rtl/bri_regfile.sv
module bri_regfile
    import bri_pkg::*;
#(
    parameter int NUM_CAL = 4,
    parameter int PW      = PAYLOAD_W,
    parameter int WW      = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [WW-1:0] word,
    input  logic          conv_done,
    input  logic          cal_done,
    output ctrl_t         ctrl,
    output logic          ctrl_wr,
    output logic [PW-1:0] test_q,
    output logic [PW-1:0] cal_q
);
    localparam int SEL_W = 2;

    target_e       tgt;
    logic [PW-1:0] cal_mem [NUM_CAL];

    assign tgt     = target_e'(word[WW-1 -: 2]);
    assign ctrl_wr = commit && (tgt == TGT_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(word[CTRL_W-1:0]);
        end else begin
            if (conv_done) ctrl.convst <= 1'b0;
            if (cal_done)  ctrl.stcal  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            test_q <= '0;
        else if (commit && tgt == TGT_TEST)
            test_q <= word[PW-1:0];
    end

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_cal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cal_mem[g] <= '0;
            else if (commit && tgt == TGT_CAL && !ctrl.stcal
                     && ctrl.calsel == SEL_W'(g))
                cal_mem[g] <= word[PW-1:0];
        end
    end

    always_comb begin
        cal_q = '0;
        for (int i = 0; i < NUM_CAL; i++)
            if (ctrl.calsel == SEL_W'(i)) cal_q = cal_mem[i];
    end

    p_rdsel_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl.rdsel));
    p_convst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && conv_done) |=> !ctrl.convst);
    p_stcal_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && cal_done) |=> !ctrl.stcal);
    p_cal_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.stcal && commit && tgt == TGT_CAL) |=> $stable(cal_q));
    p_test_target_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && tgt == TGT_TEST) |=> $stable(test_q));
endmodule

// File: rtl/bri_rd_path.sv
module bri_rd_path
    import bri_pkg::*;
#(
    parameter int PW = PAYLOAD_W,
    parameter int WW = WORD_W,
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          hben,
    input  logic          ctrl_wr,
    input  rdsrc_e        rdsel,
    input  logic [DW-1:0] result,
    input  logic [PW-1:0] test_q,
    input  logic [PW-1:0] cal_q,
    input  logic [WW-1:0] status_word,
    output logic [DW-1:0] db_out,
    output logic          db_oe
);
    localparam int BW  = BYTE_W;
    localparam int PAD = DW - BW;

    cptr_e         cp, cp_nxt;
    logic          rd_prev;
    logic          rd_act;
    logic          rd_end;
    logic [WW-1:0] rword;

    assign rd_act = !cs_n && !rd_n;
    assign rd_end = rd_prev && !rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp      <= CP_LOW;
            rd_prev <= 1'b0;
        end else begin
            cp      <= cp_nxt;
            rd_prev <= rd_act;
        end
    end

    always_comb begin
        cp_nxt = cp;
        unique case (cp)
            CP_LOW:  if (rd_end && rdsel == SRC_CAL) cp_nxt = CP_HIGH;
            CP_HIGH: if (rd_end && rdsel == SRC_CAL) cp_nxt = CP_LOW;
            default: cp_nxt = CP_LOW;
        endcase
        if (ctrl_wr) cp_nxt = CP_LOW;
    end

    always_comb begin
        unique case (rdsel)
            SRC_RESULT: rword = {{(WW-DW){1'b0}}, result};
            SRC_TEST:   rword = {{(WW-PW){1'b0}}, test_q};
            SRC_CAL:    rword = {{(WW-PW){1'b0}}, cal_q};
            SRC_STATUS: rword = status_word;
            default:    rword = '0;
        endcase
    end

    always_comb begin
        if (rdsel == SRC_CAL)
            db_out = {{PAD{1'b0}}, (cp == CP_HIGH) ? rword[WW-1 -: BW] : rword[BW-1:0]};
        else if (hben)
            db_out = {{PAD{1'b0}}, rword[WW-1 -: BW]};
        else
            db_out = rword[DW-1:0];
        db_oe = rd_act;
    end

    p_cptr_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (cp == CP_LOW));
    p_cptr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdsel != SRC_CAL && !ctrl_wr) |=> $stable(cp));
endmodule

// File: rtl/byte_reg_if.sv
module byte_reg_if
    import bri_pkg::*;
#(
    parameter int NUM_CAL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 hben,
    inout  wire  [BUS_W-1:0]     db,
    input  logic [BUS_W-1:0]     result,
    input  logic [WORD_W-1:0]    status_word,
    input  logic                 conv_done,
    input  logic                 cal_done,
    output logic [1:0]           pwr_mode,
    output logic                 range_bipolar,
    output logic                 conv_start,
    output logic                 cal_system,
    output logic [1:0]           cal_sel,
    output logic                 cal_start
);
    logic                 commit;
    logic [WORD_W-1:0]    word;
    ctrl_t                ctrl;
    logic                 ctrl_wr;
    logic [PAYLOAD_W-1:0] test_q;
    logic [PAYLOAD_W-1:0] cal_q;
    logic [BUS_W-1:0]     db_out;
    logic                 db_oe;
    logic                 unused_upper;

    assign unused_upper = ^db[BUS_W-1:BYTE_W];
    assign db = db_oe ? db_out : {BUS_W{1'bz}};

    bri_wr_assembler u_wr (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .hben(hben),
        .din(db[BYTE_W-1:0]), .commit(commit), .word(word)
    );

    bri_regfile #(.NUM_CAL(NUM_CAL)) u_rf (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
        .conv_done(conv_done), .cal_done(cal_done), .ctrl(ctrl),
        .ctrl_wr(ctrl_wr), .test_q(test_q), .cal_q(cal_q)
    );

    bri_rd_path u_rd (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .ctrl_wr(ctrl_wr), .rdsel(ctrl.rdsel), .result(result),
        .test_q(test_q), .cal_q(cal_q), .status_word(status_word),
        .db_out(db_out), .db_oe(db_oe)
    );

    assign pwr_mode      = ctrl.pmgt;
    assign range_bipolar = ctrl.amode;
    assign conv_start    = ctrl.convst;
    assign cal_system    = ctrl.calmd;
    assign cal_sel       = ctrl.calsel;
    assign cal_start     = ctrl.stcal;
endmodule

// File: tb/byte_reg_if_test.sv
`timescale 1ns/1ps
module byte_reg_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hben = 1'b0;
    logic [11:0] result = '0;
    logic [15:0] status_word = '0;
    logic        conv_done = 1'b0, cal_done = 1'b0;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_val = '0;
    wire  [11:0] db;
    logic [1:0]  pwr_mode, cal_sel;
    logic        range_bipolar, conv_start, cal_system, cal_start;

    int checks = 0, failures = 0;
    bit finished = 0;

    assign db = tb_drv ? {4'h0, tb_val} : 12'hzzz;

    always #2 clk = ~clk;

    byte_reg_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .hben(hben), .db(db), .result(result), .status_word(status_word),
        .conv_done(conv_done), .cal_done(cal_done), .pwr_mode(pwr_mode),
        .range_bipolar(range_bipolar), .conv_start(conv_start),
        .cal_system(cal_system), .cal_sel(cal_sel), .cal_start(cal_start)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int        m_pm, m_rs, m_am, m_cv, m_cm, m_cs, m_sc;
    int        m_test;
    int        m_cal [4];
    bit        m_wexp_hi, m_cp_hi, m_wr_prev, m_rd_prev;
    int        m_lo;

    function automatic int model_word();
        case (m_rs)
            0: return result;
            1: return m_test;
            2: return m_cal[m_cs];
            default: return status_word;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pm = 0; m_rs = 0; m_am = 0; m_cv = 0; m_cm = 0; m_cs = 0; m_sc = 0;
            m_test = 0; foreach (m_cal[i]) m_cal[i] = 0;
            m_wexp_hi = 0; m_cp_hi = 0; m_wr_prev = 1; m_rd_prev = 0; m_lo = 0;
        end else begin
            bit wev, ract, rend, ctl;
            int w;
            wev  = !cs_n && !wr_n && m_wr_prev;
            ract = !cs_n && !rd_n;
            rend = m_rd_prev && !ract;
            ctl  = 0;
            w    = 0;
            if (rend && m_rs == 2) m_cp_hi = !m_cp_hi;
            if (wev && !hben) begin
                m_lo = db[7:0]; m_wexp_hi = 1;
            end else if (wev && hben && m_wexp_hi) begin
                w = db[7:0] * 256 + m_lo;
                m_wexp_hi = 0;
                case (w / 16384)
                    1: m_test = w % 16384;
                    2: if (m_sc == 0) m_cal[m_cs] = w % 16384;
                    3: begin
                        ctl = 1;
                        m_pm = (w / 256) % 4; m_rs = (w / 64) % 4; m_am = (w / 32) % 2;
                        m_cv = (w / 16) % 2;  m_cm = (w / 8) % 2;  m_cs = (w / 2) % 4;
                        m_sc = w % 2; m_cp_hi = 0;
                    end
                    default: ;
                endcase
            end
            if (!ctl && conv_done) m_cv = 0;
            if (!ctl && cal_done)  m_sc = 0;
            m_wr_prev = wr_n;
            m_rd_prev = ract;
        end
        #1;
        if (!finished) begin
            chk("R5 pwr_mode", 16'(pwr_mode), 16'(m_pm));
            chk("R5 range", 16'(range_bipolar), 16'(m_am));
            chk("R6 conv_start", 16'(conv_start), 16'(m_cv));
            chk("R5 cal_system", 16'(cal_system), 16'(m_cm));
            chk("R5 cal_sel", 16'(cal_sel), 16'(m_cs));
            chk("R6 cal_start", 16'(cal_start), 16'(m_sc));
            if (!cs_n && !rd_n) begin
                int mw; int e;
                mw = model_word();
                if (m_rs == 2)   e = m_cp_hi ? (mw / 256) % 256 : mw % 256;
                else if (hben)   e = (mw / 256) % 256;
                else             e = mw % 4096;
                chk(m_rs == 2 ? "R9 bus" : "R8 bus", 16'(db), 16'(e));
            end else if (!tb_drv) begin
                checks++;
                if (db !== 12'hzzz) begin
                    failures++;
                    $display("FAIL R11 actual=%h expected=zzz", db);
                end
            end
        end
    end

    task automatic wr_byte(input logic h, input logic [7:0] b, input logic sel_n = 1'b0);
        @(negedge clk);
        cs_n = sel_n; hben = h; tb_drv = 1'b1; tb_val = b; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; tb_drv = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr_byte(1'b0, w[7:0]);
        wr_byte(1'b1, w[15:8]);
    endtask

    task automatic rd_byte(input logic h, output logic [11:0] v, input logic sel_n = 1'b0);
        @(negedge clk);
        cs_n = sel_n; rd_n = 1'b0; hben = h;
        @(posedge clk); #1;
        v = db;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 outputs", {pwr_mode, range_bipolar, conv_start, cal_system, cal_sel, cal_start}, 16'h0);
        result = 12'h5C3;
        rd_byte(1'b0, v); chk("R1 default result source", 16'(v), 16'h5C3);

        // R5: control with ignored bits 13:10, read select test
        wr_word(16'hFE40 | 16'h0220);
        chk("R5 pwr_mode", 16'(pwr_mode), 16'h2);
        chk("R5 range", 16'(range_bipolar), 16'h1);
        // R2 R4 test write and reads
        wr_word({2'b01, 14'h2A5B});
        rd_byte(1'b0, v); chk("R2 test low12", 16'(v), 16'hA5B);
        rd_byte(1'b1, v); chk("R8 test high byte", 16'(v), 16'h02A);
        wr_word({2'b00, 14'h3FFF});
        rd_byte(1'b0, v); chk("R4 no-target word", 16'(v), 16'hA5B);

        // R7 result and status sources
        wr_word(16'hC000);
        result = 12'hABC;
        rd_byte(1'b0, v); chk("R7 result", 16'(v), 16'hABC);
        rd_byte(1'b1, v); chk("R8 result high", 16'(v), 16'h00A);
        wr_word(16'hC0C0);
        status_word = 16'h5A3C;
        rd_byte(1'b0, v); chk("R7 status", 16'(v), 16'hA3C);
        rd_byte(1'b1, v); chk("R8 status high", 16'(v), 16'h05A);

        // R9 calibration bytes
        wr_word(16'hC084);
        wr_word({2'b10, 14'h1234});
        rd_byte(1'b1, v); chk("R9 cal first", 16'(v), 16'h034);
        rd_byte(1'b0, v); chk("R9 cal second", 16'(v), 16'h012);
        rd_byte(1'b0, v); chk("R9 cal wrap", 16'(v), 16'h034);
        wr_word(16'hC084);
        rd_byte(1'b0, v); chk("R9 restart", 16'(v), 16'h034);
        wr_word(16'hC082);
        rd_byte(1'b0, v); chk("R9 other reg", 16'(v), 16'h000);

        // R10 locked while calibrating, R6 clear
        wr_word(16'hC085);
        chk("R6 cal_start set", 16'(cal_start), 16'h1);
        wr_word({2'b10, 14'h0777});
        rd_byte(1'b0, v); chk("R10 locked", 16'(v), 16'h034);
        @(negedge clk); cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
        chk("R6 cal_done clears", 16'(cal_start), 16'h0);

        // R6 convert request and precedence
        wr_word(16'hC010);
        chk("R6 conv set", 16'(conv_start), 16'h1);
        @(negedge clk); conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        chk("R6 conv cleared", 16'(conv_start), 16'h0);
        wr_byte(1'b0, 8'h10);
        @(negedge clk);
        cs_n = 0; hben = 1; tb_drv = 1; tb_val = 8'hC0; wr_n = 0; conv_done = 1;
        @(negedge clk);
        wr_n = 1; cs_n = 1; tb_drv = 0; conv_done = 0;
        chk("R6 write wins", 16'(conv_start), 16'h1);

        // R3 out-of-order bytes
        wr_word(16'hC040);
        wr_byte(1'b1, 8'h7F);
        wr_byte(1'b0, 8'h11);
        wr_byte(1'b0, 8'h22);
        wr_byte(1'b1, 8'h40);
        rd_byte(1'b0, v); chk("R3 replaced low", 16'(v), 16'h022);

        // R12 / R11 deselected strobes
        wr_byte(1'b0, 8'hFF, 1'b1);
        wr_byte(1'b1, 8'h7F, 1'b1);
        rd_byte(1'b0, v, 1'b1); chk("R11 float", 16'(v === 12'hzzz), 16'h1);
        rd_byte(1'b0, v); chk("R12 ignored", 16'(v), 16'h022);
        wr_word({2'b01, 14'h0155});
        rd_byte(1'b0, v); chk("R2 pointer intact", 16'(v), 16'h155);

        idle(3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule